// File: doc/BRIEF.md
# Exception Mask Override Control

This block holds a small privileged configuration register with three override bits, one for each asynchronous exception class: external abort, normal interrupt and fast interrupt. It also holds the gating logic that turns a raw pending request into a "take" decision. The decision depends on the current security state, on a per-class route-to-monitor enable, on the status-register mask bit and on the override bit.

An override takes effect only when the core runs non-secure and the routing enable for that class is set. In that case a pending request is taken even while its mask bit is set. In secure state, or when the routing enable is clear, the override is ignored and the mask bit alone decides. The register can only be accessed by a privileged requester in secure state. Any other attempt raises a one-cycle fault flag and leaves the register untouched.

Top module: `emo_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the override field is zero, `rd_data` is zero and `acc_fault` is low.
- R2: A write with `acc_priv`=1 and `acc_secure`=1 loads `acc_wdata[8:6]` into the override field at the clock edge that samples the strobe. Bit 8 is the abort override, bit 7 the IRQ override and bit 6 the FIQ override.
- R3: Bits 31:9 and 5:0 of `rd_data` are always zero. Writing ones to those bit positions has no visible effect.
- R4: A read or write strobe with `acc_priv`=0 or `acc_secure`=0 is denied. `acc_fault` is high for exactly the one cycle after the strobe edge, `rd_data` is zero in that cycle, and the override field keeps its value.
- R5: A granted read presents the override field on `rd_data[8:6]` in the cycle after the strobe edge, with `acc_fault` low. In that cycle, `rd_data` is zero whenever no granted read was sampled. A read in the same cycle as a write returns the value held before the write.
- R6: `take[2]` (abort) is high when `pend[2]`=1 and either `psr_mask[2]`=0, or the abort override is set with `route_en[2]`=1 and `core_secure`=0.
- R7: `take[1]` (IRQ) follows the same rule using `pend[1]`, `psr_mask[1]`, `route_en[1]` and the IRQ override.
- R8: `take[0]` (FIQ) follows the same rule using `pend[0]`, `psr_mask[0]`, `route_en[0]` and the FIQ override.
- R9: When `core_secure`=1, or when the matching `route_en` bit is 0, each take output equals `pend & ~psr_mask` for its class, whatever the override.
- R10: The take outputs are combinational in the current inputs and the stored overrides. They change in the same cycle as their inputs, and are low whenever the matching pend bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_rd | input | 1 | Register read strobe |
| acc_wr | input | 1 | Register write strobe |
| acc_wdata | input | 32 | Write data |
| acc_priv | input | 1 | Requester is privileged |
| acc_secure | input | 1 | Requester is in secure state |
| core_secure | input | 1 | Core currently runs in secure state |
| route_en | input | 3 | Route-to-monitor enables: [2] abort, [1] IRQ, [0] FIQ |
| psr_mask | input | 3 | Status-register masks: [2] A, [1] I, [0] F |
| pend | input | 3 | Raw pending lines: [2] abort, [1] IRQ, [0] FIQ |
| rd_data | output | 32 | Registered read data |
| acc_fault | output | 1 | Registered denied-access flag |
| take | output | 3 | Take-exception decisions, same bit order as pend |

## Verification
The take outputs are due in the same cycle as their inputs. The bench therefore changes inputs and register-independent conditions between edges and samples `take` one time step later, with no clock edge in between. `rd_data` and `acc_fault` are due one edge after the strobe. Strobes are driven on the falling edge, held across one rising edge and sampled on the next falling edge, before any further strobe. A stored override shows its effect on `take` starting with the first cycle after its write edge, and every sweep point is checked only after that edge.

// File: rtl/emo_pkg.sv
package emo_pkg;
  localparam int EMO_DATA_W  = 32;
  localparam int EMO_NUM_EXC = 3;
  localparam int EMO_OVR_LSB = 6;

  // Class index inside every 3-bit vector of the block
  localparam int EMO_IDX_FIQ = 0;
  localparam int EMO_IDX_IRQ = 1;
  localparam int EMO_IDX_ABT = 2;
endpackage

// File: rtl/emo_regfile.sv
module emo_regfile
  import emo_pkg::*;
#(
  parameter int DATA_W  = EMO_DATA_W,
  parameter int NUM_EXC = EMO_NUM_EXC,
  parameter int OVR_LSB = EMO_OVR_LSB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               req_priv,
  input  logic               req_secure,
  output logic [NUM_EXC-1:0] ovr_q,
  output logic [DATA_W-1:0]  rdata,
  output logic               fault
);
  localparam int OVR_MSB = OVR_LSB + NUM_EXC - 1;

  logic              granted;
  logic              attempt;
  logic [DATA_W-1:0] image;

  assign granted = req_priv & req_secure;
  assign attempt = rd_en | wr_en;

  // Read image: override field in place, every other bit zero
  always_comb begin
    image = '0;
    image[OVR_MSB:OVR_LSB] = ovr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= '0;
      rdata <= '0;
      fault <= 1'b0;
    end else begin
      fault <= attempt & ~granted;
      rdata <= (rd_en & granted) ? image : '0;
      if (wr_en && granted) begin
        ovr_q <= wdata[OVR_MSB:OVR_LSB];
      end
    end
  end
endmodule

// File: rtl/emo_lane.sv
module emo_lane (
  input  logic pend,
  input  logic mask,
  input  logic ovr,
  input  logic route,
  input  logic nonsecure,
  output logic take
);
  logic ovr_live;

  assign ovr_live = ovr & route & nonsecure;
  assign take     = pend & (~mask | ovr_live);
endmodule

// File: rtl/emo_ctrl.sv
module emo_ctrl
  import emo_pkg::*;
#(
  parameter int DATA_W  = EMO_DATA_W,
  parameter int NUM_EXC = EMO_NUM_EXC,
  parameter int OVR_LSB = EMO_OVR_LSB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_rd,
  input  logic               acc_wr,
  input  logic [DATA_W-1:0]  acc_wdata,
  input  logic               acc_priv,
  input  logic               acc_secure,
  input  logic               core_secure,
  input  logic [NUM_EXC-1:0] route_en,
  input  logic [NUM_EXC-1:0] psr_mask,
  input  logic [NUM_EXC-1:0] pend,
  output logic [DATA_W-1:0]  rd_data,
  output logic               acc_fault,
  output logic [NUM_EXC-1:0] take
);
  logic [NUM_EXC-1:0] ovr_q;

  emo_regfile #(
    .DATA_W (DATA_W),
    .NUM_EXC(NUM_EXC),
    .OVR_LSB(OVR_LSB)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (acc_rd),
    .wr_en     (acc_wr),
    .wdata     (acc_wdata),
    .req_priv  (acc_priv),
    .req_secure(acc_secure),
    .ovr_q     (ovr_q),
    .rdata     (rd_data),
    .fault     (acc_fault)
  );

  for (genvar g = 0; g < NUM_EXC; g++) begin : g_lane
    emo_lane u_lane (
      .pend     (pend[g]),
      .mask     (psr_mask[g]),
      .ovr      (ovr_q[g]),
      .route    (route_en[g]),
      .nonsecure(~core_secure),
      .take     (take[g])
    );
  end
endmodule

// File: rtl/emo_ctrl_chk.sv
module emo_ctrl_chk #(
  parameter int DATA_W  = 32,
  parameter int NUM_EXC = 3,
  parameter int OVR_LSB = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               acc_rd,
  input logic               acc_wr,
  input logic [DATA_W-1:0]  acc_wdata,
  input logic               acc_priv,
  input logic               acc_secure,
  input logic               core_secure,
  input logic [NUM_EXC-1:0] route_en,
  input logic [NUM_EXC-1:0] psr_mask,
  input logic [NUM_EXC-1:0] pend,
  input logic [DATA_W-1:0]  rd_data,
  input logic               acc_fault,
  input logic [NUM_EXC-1:0] take,
  input logic [NUM_EXC-1:0] ovr_q
);
  localparam logic [DATA_W-1:0] FIELD =
    {{(DATA_W-NUM_EXC){1'b0}}, {NUM_EXC{1'b1}}} << OVR_LSB;

  logic ok_req;
  logic denied;
  assign ok_req = acc_priv & acc_secure;
  assign denied = (acc_rd | acc_wr) & ~ok_req;

  // R4
  a_r4_fault_on_denied: assert property (@(posedge clk) disable iff (rst)
    denied |=> acc_fault);
  // R4
  a_r4_no_fault_otherwise: assert property (@(posedge clk) disable iff (rst)
    !denied |=> !acc_fault);
  // R4
  a_r4_denied_write_keeps: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && !ok_req) |=> $stable(ovr_q));
  // R2
  a_r2_write_loads: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && ok_req) |=> (ovr_q == $past(acc_wdata[OVR_LSB +: NUM_EXC])));
  // R5
  a_r5_read_returns: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && ok_req) |=> (rd_data[OVR_LSB +: NUM_EXC] == $past(ovr_q)));
  // R4 / R5
  a_r5_idle_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !(acc_rd && ok_req) |=> (rd_data == '0));
  // R3
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    ((rd_data & ~FIELD) == '0));
  // R9
  a_r9_secure_ignores: assert property (@(posedge clk) disable iff (rst)
    core_secure |-> (take == (pend & ~psr_mask)));
  // R9
  a_r9_unrouted_ignores: assert property (@(posedge clk) disable iff (rst)
    (route_en == '0) |-> (take == (pend & ~psr_mask)));
  // R10
  a_r10_no_take_idle: assert property (@(posedge clk) disable iff (rst)
    ((take & ~pend) == '0));
  // R6 / R7 / R8: an unmasked pending request is always taken
  a_r6_unmasked_taken: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~psr_mask & ~take) == '0));
endmodule

bind emo_ctrl emo_ctrl_chk #(
  .DATA_W (DATA_W),
  .NUM_EXC(NUM_EXC),
  .OVR_LSB(OVR_LSB)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_rd     (acc_rd),
  .acc_wr     (acc_wr),
  .acc_wdata  (acc_wdata),
  .acc_priv   (acc_priv),
  .acc_secure (acc_secure),
  .core_secure(core_secure),
  .route_en   (route_en),
  .psr_mask   (psr_mask),
  .pend       (pend),
  .rd_data    (rd_data),
  .acc_fault  (acc_fault),
  .take       (take),
  .ovr_q      (ovr_q)
);

// File: tb/emo_ctrl_bench.sv
`timescale 1ns/1ps
module emo_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_rd = 1'b0, acc_wr = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic        acc_priv = 1'b0, acc_secure = 1'b0;
  logic        core_secure = 1'b1;
  logic [2:0]  route_en = '0, psr_mask = '0, pend = '0;
  logic [31:0] rd_data;
  logic        acc_fault;
  logic [2:0]  take;

  int total = 0;
  int bad   = 0;
  logic [2:0] m_ovr = '0;

  always #2 clk = ~clk;

  emo_ctrl u_emo_ctrl (
    .clk(clk), .rst(rst), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .acc_priv(acc_priv), .acc_secure(acc_secure),
    .core_secure(core_secure), .route_en(route_en), .psr_mask(psr_mask),
    .pend(pend), .rd_data(rd_data), .acc_fault(acc_fault), .take(take)
  );

  function automatic logic [2:0] exp_take(input logic sec, input logic [2:0] rt,
                                          input logic [2:0] mk, input logic [2:0] pd,
                                          input logic [2:0] ov);
    logic [2:0] r;
    for (int i = 0; i < 3; i++)
      r[i] = pd[i] && (!mk[i] || (ov[i] && rt[i] && !sec));
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One strobe cycle; registered response checked on the following falling edge
  task automatic access(input logic rd, input logic wr, input logic pv,
                        input logic sc, input logic [31:0] wd, input string req);
    logic        ok;
    logic [31:0] exp_rd;
    ok = pv && sc;
    exp_rd = (rd && ok) ? {23'b0, m_ovr, 6'b0} : 32'h0;
    @(negedge clk);
    acc_rd = rd; acc_wr = wr; acc_priv = pv; acc_secure = sc; acc_wdata = wd;
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
    if (wr && ok) m_ovr = wd[8:6];
    check({req, " fault"}, {31'b0, acc_fault}, {31'b0, (rd || wr) && !ok});
    check({req, " rdata"}, rd_data, exp_rd);
  endtask

  task automatic check_take(input string req);
    #1;
    check(req, {29'b0, take}, {29'b0, exp_take(core_secure, route_en, psr_mask, pend, m_ovr)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 fault", {31'b0, acc_fault}, 32'h0);
    access(1'b1, 1'b0, 1'b1, 1'b1, 32'h0, "R1 readback");

    // R2/R3 granted write of all ones, reserved bits stay zero
    access(1'b0, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, "R2 write");
    access(1'b1, 1'b0, 1'b1, 1'b1, 32'h0, "R3 read");
    check("R3 reserved", rd_data & 32'hFFFF_FE3F, 32'h0);
    // R4 denied writes: user mode, non-secure, both
    access(1'b0, 1'b1, 1'b0, 1'b1, 32'h0, "R4 user write");
    access(1'b0, 1'b1, 1'b1, 1'b0, 32'h0, "R4 nonsec write");
    access(1'b1, 1'b0, 1'b0, 1'b0, 32'h0, "R4 denied read");
    access(1'b1, 1'b0, 1'b1, 1'b1, 32'h0, "R4 kept");
    // R5 read and write together returns old value
    access(1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0080, "R5 rd+wr");
    access(1'b1, 1'b0, 1'b1, 1'b1, 32'h0, "R5 new value");
    // R5 idle cycle reads zero, no fault
    @(negedge clk);
    check("R5 idle rdata", rd_data, 32'h0);
    check("R4 idle fault", {31'b0, acc_fault}, 32'h0);

    // Exhaustive sweep per class: sec, route, mask, ovr
    for (int e = 0; e < 3; e++) begin
      for (int c = 0; c < 16; c++) begin
        string tag;
        access(1'b0, 1'b1, 1'b1, 1'b1, {23'b0, 3'(c[0]) << e, 6'b0}, "R2 sweep write");
        core_secure = c[3];
        route_en = 3'(c[2]) << e;
        psr_mask = 3'(c[1]) << e;
        tag = (e == 2) ? "R6 abort" : (e == 1) ? "R7 irq" : "R8 fiq";
        if (c[3] || !c[2]) tag = {tag, " R9 ignored"};
        pend = 3'b111;
        check_take(tag);
        pend = 3'b000;
        check_take("R10 no pend");
      end
    end

    // R10: combinational response mid-cycle, no clock edge between
    @(negedge clk);
    core_secure = 1'b0; route_en = 3'b111; psr_mask = 3'b000; pend = 3'b000;
    #0.3 pend = 3'b101;
    check_take("R10 same cycle");

    // Random mix
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 3) == 0)
        access($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
               $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, $urandom, "R4 random access");
      @(negedge clk);
      core_secure = $urandom_range(0, 1) == 1;
      route_en = 3'($urandom); psr_mask = 3'($urandom); pend = 3'($urandom);
      check_take("R6 R7 R8 random take");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule